// File: doc/BRIEF.md
# ADC Scan-Mode Conversion Sequencer

This block controls a multi-channel analog-to-digital converter in continuous scan mode. A start bit is set by any of three pulses: a software set strobe, a timer trigger or an external trigger. A software clear strobe resets it. While the start bit is high, the block works through a group of up to four adjacent channels, one at a time. It starts a conversion on an abstract converter core through a request/done handshake and writes each returned sample into that channel's slot of a result bank.

Two group-select bits choose the first channel of the group. Two count-select bits choose how many channels a pass covers. At the end of each pass an end flag is set, and it stays set until software clears it. The interrupt output is that flag gated by an enable input. The block then goes back to the group's first channel and carries on. When the start bit is cleared, any conversion in flight is dropped and the block waits. The next start always begins again at the first channel of the group.

Top module: `adc_scan_seq`

## Requirements
- R1: `cnv_req_o` goes high to launch one conversion and stays high until the cycle in which `cnv_done_i` is sampled high. It is low for the next cycle. Only one conversion is in flight at a time, and `cnv_done_i` is ignored while `cnv_req_o` is low.
- R2: `cnv_ch_o` is `{grp_sel_i, slot}`. The group bases are 00 = channel 0, 01 = channel 4, 10 = channel 8 and 11 = channel 12. A pass covers slots 0 to `cnt_sel_i` in upward order, which is 1 to 4 channels.
- R3: A one-cycle pulse on `sw_start_set_i`, `tmr_trig_i` or `ext_trig_i` sets `start_o` on the next edge. `cnv_req_o` rises one cycle after `start_o`.
- R4: When a conversion completes, `cnv_data_i` is written into slot k of `res_o` (bits `[k*DATA_W +: DATA_W]`) on that edge. k is the slot of the channel being converted. The other slots keep their values.
- R5: `flag_o` is set on the edge where the last slot of a pass completes. It then holds until a `flag_clr_i` pulse clears it. If both happen on the same edge, the set wins.
- R6: `irq_o` is high exactly when `flag_o` and `irq_en_i` are both high.
- R7: While `start_o` stays high, the request after the last slot of a pass targets slot 0 of the group again.
- R8: `sw_start_clr_i` clears `start_o` on the next edge and wins over any set source on the same edge. `cnv_req_o` is low from that edge on.
- R9: After a stop, the next start begins at slot 0, whatever slot was active when the scan stopped.
- R10: A conversion that is stopped by `sw_start_clr_i` leaves `res_o` and `flag_o` unchanged. This includes the case where `cnv_done_i` arrives on that same edge.
- R11: A trigger or set pulse while `start_o` is high has no effect on the slot order or on the conversion in flight.
- R12: After reset, `start_o`, `cnv_req_o`, `flag_o`, `irq_o`, `cnv_ch_o` slot bits and every slot of `res_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_start_set_i | input | 1 | Software pulse that sets the start bit |
| sw_start_clr_i | input | 1 | Software pulse that clears the start bit |
| tmr_trig_i | input | 1 | Timer trigger pulse |
| ext_trig_i | input | 1 | External trigger pulse |
| grp_sel_i | input | GRP_W | Group select, base channel = 4 × value |
| cnt_sel_i | input | IDX_W | Number of channels per pass, minus one |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Software pulse that clears the end flag |
| cnv_done_i | input | 1 | Converter reports that the sample is ready |
| cnv_data_i | input | DATA_W | Converter sample |
| start_o | output | 1 | Current start bit |
| cnv_req_o | output | 1 | Conversion request to the converter |
| cnv_ch_o | output | GRP_W+IDX_W | Channel being converted |
| res_o | output | GRP_SIZE×DATA_W | Result slots, slot k at bits [k*DATA_W +: DATA_W] |
| flag_o | output | 1 | End-of-pass flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: 10-bit samples, groups of four and two group-select bits. All four bases and all four pass lengths are therefore reachable, from a one-channel pass that sets the flag after every conversion up to a full four-slot pass. A converter stub in the bench gives each channel its own latency, so completions land on different cycles relative to triggers and stop pulses. One stop pulse is timed to the exact cycle in which a sample returns.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_CONV = 1'b1
  } seq_state_e;
endpackage

// File: rtl/adc_start_ctl.sv
module adc_start_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_set_i,
  input  logic tmr_trig_i,
  input  logic ext_trig_i,
  input  logic sw_clr_i,
  output logic start_o,
  output logic run_o
);
  logic start_q;
  logic any_set;

  assign any_set = sw_set_i | tmr_trig_i | ext_trig_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       start_q <= 1'b0;
    else if (sw_clr_i) start_q <= 1'b0;
    else if (any_set)  start_q <= 1'b1;
  end

  assign start_o = start_q;
  // clear takes effect on the sequencer in the same cycle
  assign run_o   = start_q & ~sw_clr_i;
endmodule

// File: rtl/adc_chan_seq.sv
module adc_chan_seq
  import adc_scan_pkg::*;
#(
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [IDX_W-1:0] cnt_sel_i,
  input  logic             cnv_done_i,
  output logic             req_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             wr_en_o,
  output logic             pass_end_o
);
  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             last_slot;

  assign last_slot = (idx_q == cnt_sel_i);

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    wr_en_o    = 1'b0;
    pass_end_o = 1'b0;
    if (!run_i) begin
      state_d = SEQ_IDLE;
      idx_d   = '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: state_d = SEQ_CONV;
        SEQ_CONV: begin
          if (cnv_done_i) begin
            wr_en_o = 1'b1;
            state_d = SEQ_IDLE;
            if (last_slot) begin
              idx_d      = '0;
              pass_end_o = 1'b1;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign req_o = (state_q == SEQ_CONV);
  assign idx_o = idx_q;
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int unsigned GRP_SIZE = 4,
  parameter int unsigned DATA_W   = 10,
  parameter int unsigned IDX_W    = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic [GRP_SIZE*DATA_W-1:0] res_o
);
  for (genvar k = 0; k < GRP_SIZE; k++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        slot_q <= '0;
      else if (wr_en_i && (wr_idx_i == IDX_W'(k)))
        slot_q <= wr_data_i;
    end
    assign res_o[k*DATA_W +: DATA_W] = slot_q;
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int unsigned DATA_W   = 10,
  parameter int unsigned GRP_SIZE = 4,
  parameter int unsigned GRP_W    = 2,
  localparam int unsigned IDX_W   = $clog2(GRP_SIZE),
  localparam int unsigned CH_W    = GRP_W + IDX_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sw_start_set_i,
  input  logic                       sw_start_clr_i,
  input  logic                       tmr_trig_i,
  input  logic                       ext_trig_i,
  input  logic [GRP_W-1:0]           grp_sel_i,
  input  logic [IDX_W-1:0]           cnt_sel_i,
  input  logic                       irq_en_i,
  input  logic                       flag_clr_i,
  input  logic                       cnv_done_i,
  input  logic [DATA_W-1:0]          cnv_data_i,
  output logic                       start_o,
  output logic                       cnv_req_o,
  output logic [CH_W-1:0]            cnv_ch_o,
  output logic [GRP_SIZE*DATA_W-1:0] res_o,
  output logic                       flag_o,
  output logic                       irq_o
);
  logic             run;
  logic [IDX_W-1:0] idx;
  logic             wr_en;
  logic             pass_end;
  logic             flag_q;

  adc_start_ctl u_start (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_set_i   (sw_start_set_i),
    .tmr_trig_i (tmr_trig_i),
    .ext_trig_i (ext_trig_i),
    .sw_clr_i   (sw_start_clr_i),
    .start_o    (start_o),
    .run_o      (run)
  );

  adc_chan_seq #(.IDX_W(IDX_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .cnt_sel_i  (cnt_sel_i),
    .cnv_done_i (cnv_done_i),
    .req_o      (cnv_req_o),
    .idx_o      (idx),
    .wr_en_o    (wr_en),
    .pass_end_o (pass_end)
  );

  adc_result_bank #(
    .GRP_SIZE (GRP_SIZE),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (idx),
    .wr_data_i (cnv_data_i),
    .res_o     (res_o)
  );

  // set has priority over a simultaneous software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (pass_end)   flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign cnv_ch_o = {grp_sel_i, idx};
  assign flag_o   = flag_q;
  assign irq_o    = flag_q & irq_en_i;
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sw_start_clr_i,
  input logic flag_clr_i,
  input logic cnv_done_i,
  input logic start_o,
  input logic cnv_req_o,
  input logic flag_o,
  input logic irq_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnv_req_o && !cnv_done_i && !sw_start_clr_i |=> cnv_req_o); // R1

  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnv_req_o && cnv_done_i |=> !cnv_req_o); // R1

  AST_REQ_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnv_req_o |-> start_o); // R3

  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !flag_clr_i |=> flag_o); // R5

  AST_FLAG_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(cnv_req_o && cnv_done_i && !sw_start_clr_i)); // R5

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o); // R6

  AST_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_start_clr_i |=> !start_o && !cnv_req_o); // R8
endmodule

bind adc_scan_seq adc_scan_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sw_start_clr_i (sw_start_clr_i),
  .flag_clr_i     (flag_clr_i),
  .cnv_done_i     (cnv_done_i),
  .start_o        (start_o),
  .cnv_req_o      (cnv_req_o),
  .flag_o         (flag_o),
  .irq_o          (irq_o)
);

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/1ps
module adc_scan_seq_tb;
  localparam int DW = 10;
  localparam int GS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_set = 0, sw_clr = 0, abort_clr = 0, tmr = 0, ext = 0;
  logic [1:0] grp = 0, cnt = 0;
  logic ie = 0, fclr = 0, done = 0;
  logic [DW-1:0] data = 0;
  logic start, req, flag, irq;
  logic [3:0] ch;
  logic [GS*DW-1:0] res;
  logic clr_w;

  assign clr_w = sw_clr | abort_clr;

  always #2.5 clk = ~clk;

  adc_scan_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .sw_start_set_i(sw_set), .sw_start_clr_i(clr_w),
    .tmr_trig_i(tmr), .ext_trig_i(ext),
    .grp_sel_i(grp), .cnt_sel_i(cnt), .irq_en_i(ie), .flag_clr_i(fclr),
    .cnv_done_i(done), .cnv_data_i(data),
    .start_o(start), .cnv_req_o(req), .cnv_ch_o(ch), .res_o(res),
    .flag_o(flag), .irq_o(irq)
  );

  int checks = 0, fails = 0, cycles = 0, seq = 0, wait_cnt = 0;
  bit abort_on_done = 0;

  // reference model state
  bit m_st, m_busy, m_flag;
  int m_idx;
  logic [DW-1:0] m_res [GS];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_busy = 0; m_flag = 0; m_idx = 0;
      for (int k = 0; k < GS; k++) m_res[k] = '0;
    end else begin
      bit pass_end;
      pass_end = 0;
      if (!m_st || clr_w) begin
        m_busy = 0; m_idx = 0;          // R10: in-flight result dropped
      end else if (!m_busy) begin
        m_busy = 1;
      end else if (done) begin
        m_res[m_idx] = data;
        if (m_idx == int'(cnt)) begin m_idx = 0; pass_end = 1; end
        else m_idx++;
        m_busy = 0;
      end
      if (pass_end) m_flag = 1;
      else if (fclr) m_flag = 0;
      if (clr_w) m_st = 0;
      else if (sw_set || tmr || ext) m_st = 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // compare, converter stub, watchdog: all at the falling edge
  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected < 100000 cycles", cycles);
      finish_run();
    end
    if (rst_n) begin
      chk("R3/R8 start_o", start, m_st);
      chk("R1 cnv_req_o", req, m_busy);
      if (m_busy) chk("R2/R7/R9 cnv_ch_o", ch, {grp, 2'(m_idx)});
      for (int k = 0; k < GS; k++) chk("R4/R10 res_o slot", res[k*DW +: DW], m_res[k]);
      chk("R5 flag_o", flag, m_flag);
      chk("R6 irq_o", irq, m_flag & ie);
    end
    abort_clr = 0;
    done = 0;
    if (req) begin
      wait_cnt++;
      if (wait_cnt == 1 + int'(ch) % 3) begin
        done = 1;
        data = DW'(int'(ch) * 37 + seq * 5 + 1);
        seq++;
        wait_cnt = 0;
        if (abort_on_done) begin abort_clr = 1; abort_on_done = 0; end
      end
    end else wait_cnt = 0;
  end

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic wait_req_rise(output logic [3:0] first_ch);
    do @(negedge clk); while (!req);
    first_ch = ch;
  endtask

  initial begin
    logic [3:0] c;
    repeat (3) @(negedge clk);
    chk("R12 reset start_o", start, 0);
    chk("R12 reset cnv_req_o", req, 0);
    chk("R12 reset flag_o", flag, 0);
    chk("R12 reset irq_o", irq, 0);
    chk("R12 reset res_o", res, 0);
    rst_n = 1;

    // full group at base 4, software start
    grp = 2'b01; cnt = 2'd3; ie = 1;
    pulse(sw_set);
    chk("R3 start_o after set pulse", start, 1);
    wait_req_rise(c);
    chk("R2 first channel of group 01", c, 4'd4);
    repeat (50) @(negedge clk);
    chk("R5 flag after full pass", flag, 1);
    chk("R6 irq with enable", irq, 1);
    pulse(fclr);
    repeat (3) @(negedge clk);
    pulse(tmr);                         // R11: ignored while running
    repeat (10) @(negedge clk);
    pulse(ext);                         // R11
    repeat (40) @(negedge clk);

    // stop mid conversion, restart from base via external trigger
    do @(negedge clk); while (!(req && ch == 4'd6));
    sw_clr = 1; @(negedge clk); sw_clr = 0;
    chk("R8 start cleared", start, 0);
    repeat (5) @(negedge clk);
    ext = 1; @(negedge clk); ext = 0;
    wait_req_rise(c);
    chk("R9 restart at base", c, 4'd4);
    repeat (30) @(negedge clk);

    // single-channel pass at base 12, timer start, irq disabled
    sw_clr = 1; @(negedge clk); sw_clr = 0;
    pulse(fclr);
    grp = 2'b11; cnt = 2'd0; ie = 0;
    pulse(tmr);
    repeat (30) @(negedge clk);
    chk("R6 irq low with enable off", irq, 0);
    chk("R5 flag set by one-slot pass", flag, 1);
    pulse(fclr);
    repeat (10) @(negedge clk);

    // two-channel pass at base 8, stop on the completion cycle
    sw_clr = 1; @(negedge clk); sw_clr = 0;
    pulse(fclr);
    grp = 2'b10; cnt = 2'd1; ie = 1;
    pulse(sw_set);
    repeat (40) @(negedge clk);
    pulse(fclr);
    abort_on_done = 1;                  // R10
    repeat (20) @(negedge clk);
    chk("R8 stopped by clear on done", start, 0);
    pulse(sw_set);
    wait_req_rise(c);
    chk("R9 restart at base 8", c, 4'd8);
    repeat (30) @(negedge clk);
    pulse(sw_clr);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule